// File: doc/BRIEF.md
# Capture/Compare Timer-Counter

This block is a memory-mapped timer/counter with four capture/compare channels and a single interrupt line. It has two modes. In timer mode it advances on a tick derived from the system clock and divided by a power of two. In counter mode it advances only when software writes a count task. The counter width can be 8, 16, 24 or 32 bits. The counter wraps to zero past the top of the selected width.

Each channel holds a compare value. When the counter steps onto that value, the channel raises a sticky event flag. Per-channel shortcut bits let that compare also zero the counter or halt timer counting. Software enables interrupts per channel through separate set and clear registers.

Capture tasks copy the live counter into a channel's compare register. The counter has no register of its own, so capture is also how software reads it. All registers are 32-bit words on a simple select/write-enable bus with a combinational read path.

Top module: `cct_timer`

## Requirements
- R1: In timer mode (MODE 0) a running counter advances once every 2^P clock cycles, where P is the 4-bit prescale field at offset 0x58. Bits above bit 3 are dropped on write. After the START write takes effect, the first advance comes 2^P cycles later.
- R2: The width code at offset 0x54 selects the counter width: 1 gives 8 bits, 0 gives 16, 2 gives 24 and 3 gives 32. Advancing from the all-ones value of that width gives 0.
- R3: A write to compare register i (offset 0x60+4i) stores the value masked to the current width.
- R4: Event flag i (offset 0x30+4i, read in bit 0) sets on the cycle the counter advances onto compare value i and stays set. Writing 0 there clears it, and any other written value leaves it unchanged.
- R5: In the shortcut register at offset 0x40, bit i makes a compare on channel i load 0 into the counter instead of the compare value. Bit 8+i makes a compare on channel i stop timer counting.
- R6: The irq output is high when any channel has both its event flag set and its enable bit set.
- R7: The enable bits sit at bits 16+i. Writing offset 0x44 sets the written enable bits, and writing offset 0x48 clears them. Reading either offset returns the enable bits in place.
- R8: Writing 1 to START (0x00) makes the counter run only when MODE (0x50, bit 0) is 0. Writing 1 to STOP (0x04) or SHUTDOWN (0x10) halts it.
- R9: Writing 1 to COUNT (0x08) advances the counter by one, with compare checking, only when MODE is 1. In counter mode the counter never changes without a bus write.
- R10: Writing 1 to CLEAR (0x0C) zeroes the counter. Writing 1 to CAPTURE i (0x20+4i) copies the counter into compare register i. A task write of any value other than 1 does nothing.
- R11: After reset the counter, compare registers, event flags, shortcuts, enables, mode, width code and prescale are all 0, and the counter is stopped.
- R12: Reads of unmapped offsets and of task offsets return 0. Writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the undivided timer tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte offset of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 1 | Interrupt request |

## Verification
Several behaviours are checked by properties on every cycle. Counter mode must hold the counter still with no bus write, and a wrap from the width's all-ones value must land on zero. A stop shortcut must drop the running state on the next cycle, an event flag may rise only after its channel matched, and a clear of all enables must silence the interrupt at once. The prescaler is checked so that it never ticks on the first running cycle with a nonzero prescale. Exact advance counts for a given prescale, the masking of stored compare values, a clear shortcut returning the counter to zero, the ignored START in counter mode and the reset values are visible only at the bus. The bench's scenarios show them through capture and readback.

// File: rtl/cct_pkg.sv
package cct_pkg;
  localparam int REG_AW = 8;
  localparam int DW     = 32;

  typedef enum logic {
    MODE_TIMER   = 1'b0,
    MODE_COUNTER = 1'b1
  } cct_mode_e;

  localparam logic [REG_AW-1:0] A_START  = 8'h00;
  localparam logic [REG_AW-1:0] A_STOP   = 8'h04;
  localparam logic [REG_AW-1:0] A_COUNT  = 8'h08;
  localparam logic [REG_AW-1:0] A_CLEAR  = 8'h0C;
  localparam logic [REG_AW-1:0] A_SHUT   = 8'h10;
  localparam logic [REG_AW-1:0] A_CAP0   = 8'h20;
  localparam logic [REG_AW-1:0] A_EV0    = 8'h30;
  localparam logic [REG_AW-1:0] A_SHORT  = 8'h40;
  localparam logic [REG_AW-1:0] A_IENSET = 8'h44;
  localparam logic [REG_AW-1:0] A_IENCLR = 8'h48;
  localparam logic [REG_AW-1:0] A_MODE   = 8'h50;
  localparam logic [REG_AW-1:0] A_WIDTH  = 8'h54;
  localparam logic [REG_AW-1:0] A_PRESC  = 8'h58;
  localparam logic [REG_AW-1:0] A_CC0    = 8'h60;

  localparam int IEN_LSB  = 16;
  localparam int STOP_LSB = 8;

  function automatic logic [DW-1:0] width_mask(input logic [1:0] code);
    case (code)
      2'd0:    width_mask = 32'h0000_FFFF;
      2'd1:    width_mask = 32'h0000_00FF;
      2'd2:    width_mask = 32'h00FF_FFFF;
      default: width_mask = 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/cct_prescaler.sv
module cct_prescaler #(
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] presc,
  output logic             tick
);
  localparam int PC_W = (1 << PRE_W) - 1;

  logic [PC_W-1:0] pc_q, pc_d, div_mask;

  always_comb begin
    div_mask = PC_W'((32'd1 << presc) - 32'd1);
    tick     = run && ((pc_q & div_mask) == div_mask);
    pc_d     = run ? pc_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  // R1
  first_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(run) && presc != '0) |-> !tick);
endmodule

// File: rtl/cct_channel.sv
module cct_channel #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cc_we,
  input  logic [DW-1:0] cc_wval,
  input  logic          cap_we,
  input  logic [DW-1:0] cnt_q,
  input  logic          adv,
  input  logic [DW-1:0] cnt_nx,
  input  logic          ev_clr,
  output logic          match,
  output logic [DW-1:0] cc_q,
  output logic          ev_q
);
  logic [DW-1:0] cc_d;
  logic          ev_d;

  always_comb begin
    match = adv && (cnt_nx == cc_q);
    if (cap_we)     cc_d = cnt_q;
    else if (cc_we) cc_d = cc_wval;
    else            cc_d = cc_q;
    if (match)       ev_d = 1'b1;
    else if (ev_clr) ev_d = 1'b0;
    else             ev_d = ev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cc_q <= '0;
      ev_q <= 1'b0;
    end else begin
      cc_q <= cc_d;
      ev_q <= ev_d;
    end
  end

  // R4
  ev_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_q) |-> $past(match));
endmodule

// File: rtl/cct_timer.sv
module cct_timer
  import cct_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int PRE_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq
);
  localparam logic [DW-1:0] TRIG = 32'd1;

  logic              wr, trig;
  logic              t_start, t_stop, t_count, t_clear, adv, tick;
  logic [DW-1:0]     cnt_q, cnt_d, cnt_nx, wmask;
  logic              run_q, run_d;
  cct_mode_e         mode_q, mode_d;
  logic [1:0]        wcode_q, wcode_d;
  logic [PRE_W-1:0]  presc_q, presc_d;
  logic [NUM_CH-1:0] sh_clr_q, sh_clr_d, sh_stop_q, sh_stop_d, ien_q, ien_d;
  logic [NUM_CH-1:0] cc_we, cap_we, ev_clr, match, ev_q;
  logic [DW-1:0]     cc_q [NUM_CH];
  logic              clr_hit, stop_hit;

  assign wr      = bus_sel && bus_we;
  assign trig    = wr && (bus_wdata == TRIG);
  assign t_start = trig && bus_addr == A_START && mode_q == MODE_TIMER;
  assign t_stop  = trig && (bus_addr == A_STOP || bus_addr == A_SHUT);
  assign t_count = trig && bus_addr == A_COUNT && mode_q == MODE_COUNTER;
  assign t_clear = trig && bus_addr == A_CLEAR;
  assign wmask   = width_mask(wcode_q);
  assign cnt_nx  = (cnt_q + 1'b1) & wmask;
  assign adv     = (run_q && tick && mode_q == MODE_TIMER) || t_count;

  cct_prescaler #(.PRE_W(PRE_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(run_q), .presc(presc_q), .tick(tick)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign cc_we[i]  = wr && bus_addr == REG_AW'(A_CC0 + 4*i);
    assign cap_we[i] = trig && bus_addr == REG_AW'(A_CAP0 + 4*i);
    assign ev_clr[i] = wr && bus_addr == REG_AW'(A_EV0 + 4*i) && bus_wdata == '0;

    cct_channel #(.DW(DW)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .cc_we(cc_we[i]), .cc_wval(bus_wdata & wmask), .cap_we(cap_we[i]),
      .cnt_q(cnt_q), .adv(adv), .cnt_nx(cnt_nx), .ev_clr(ev_clr[i]),
      .match(match[i]), .cc_q(cc_q[i]), .ev_q(ev_q[i])
    );
  end

  assign clr_hit  = |(match & sh_clr_q);
  assign stop_hit = |(match & sh_stop_q);
  assign irq      = |(ev_q & ien_q);

  always_comb begin
    cnt_d     = cnt_q;
    run_d     = run_q;
    mode_d    = mode_q;
    wcode_d   = wcode_q;
    presc_d   = presc_q;
    sh_clr_d  = sh_clr_q;
    sh_stop_d = sh_stop_q;
    ien_d     = ien_q;

    if (t_clear)  cnt_d = '0;
    else if (adv) cnt_d = clr_hit ? '0 : cnt_nx;

    if (t_stop)        run_d = 1'b0;
    else if (t_start)  run_d = 1'b1;
    else if (stop_hit) run_d = 1'b0;

    if (wr) begin
      case (bus_addr)
        A_SHORT: begin
          sh_clr_d  = bus_wdata[NUM_CH-1:0];
          sh_stop_d = bus_wdata[STOP_LSB +: NUM_CH];
        end
        A_IENSET: ien_d   = ien_q | bus_wdata[IEN_LSB +: NUM_CH];
        A_IENCLR: ien_d   = ien_q & ~bus_wdata[IEN_LSB +: NUM_CH];
        A_MODE:   mode_d  = cct_mode_e'(bus_wdata[0]);
        A_WIDTH:  wcode_d = bus_wdata[1:0];
        A_PRESC:  presc_d = bus_wdata[PRE_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      run_q     <= 1'b0;
      mode_q    <= MODE_TIMER;
      wcode_q   <= '0;
      presc_q   <= '0;
      sh_clr_q  <= '0;
      sh_stop_q <= '0;
      ien_q     <= '0;
    end else begin
      cnt_q     <= cnt_d;
      run_q     <= run_d;
      mode_q    <= mode_d;
      wcode_q   <= wcode_d;
      presc_q   <= presc_d;
      sh_clr_q  <= sh_clr_d;
      sh_stop_q <= sh_stop_d;
      ien_q     <= ien_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_SHORT: begin
        bus_rdata[NUM_CH-1:0]        = sh_clr_q;
        bus_rdata[STOP_LSB +: NUM_CH] = sh_stop_q;
      end
      A_IENSET, A_IENCLR: bus_rdata[IEN_LSB +: NUM_CH] = ien_q;
      A_MODE:  bus_rdata[0]       = mode_q;
      A_WIDTH: bus_rdata[1:0]     = wcode_q;
      A_PRESC: bus_rdata[PRE_W-1:0] = presc_q;
      default: ;
    endcase
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_addr == REG_AW'(A_CC0 + 4*i)) bus_rdata = cc_q[i];
      if (bus_addr == REG_AW'(A_EV0 + 4*i)) bus_rdata = {{(DW-1){1'b0}}, ev_q[i]};
    end
  end

  // R9
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_COUNTER && !wr) |=> $stable(cnt_q));
  // R2
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !t_clear && !clr_hit && cnt_q == wmask) |=> cnt_q == '0);
  // R5
  stop_sh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_hit && !t_start) |=> !run_q);
  // R7
  ien_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_IENCLR && &bus_wdata[IEN_LSB +: NUM_CH]) |=> !irq);
endmodule

// File: tb/cct_timer_bench.sv
module cct_timer_bench;
  import cct_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int          n_chk = 0;
  int          n_bad = 0;

  always #5 clk = ~clk;

  cct_timer u_cct_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 8'h40, 32'h0, 4'd11},          // R11 shortcuts reset
    '{1'b0, 8'h60, 32'h0, 4'd11},          // R11 compare reset
    '{1'b0, 8'h54, 32'h0, 4'd11},          // R11 width reset
    '{1'b1, 8'h50, 32'h1, 4'd9},           // counter mode
    '{1'b1, 8'h54, 32'h1, 4'd2},           // 8-bit width
    '{1'b1, 8'h60, 32'h1234, 4'd3},
    '{1'b0, 8'h60, 32'h34, 4'd3},          // R3 masked store
    '{1'b1, 8'h64, 32'h2, 4'd3},
    '{1'b1, 8'h08, 32'h1, 4'd9},
    '{1'b1, 8'h08, 32'h1, 4'd9},           // counter now 2, channel 1 matches
    '{1'b0, 8'h34, 32'h1, 4'd4},           // R4 event set
    '{1'b0, 8'h30, 32'h0, 4'd4},           // R4 other event quiet
    '{1'b1, 8'h44, 32'hFFFF_FFFF, 4'd7},
    '{1'b0, 8'h48, 32'h000F_0000, 4'd7},   // R7 set masked, read via clr
    '{1'b1, 8'h48, 32'h0001_0000, 4'd7},
    '{1'b0, 8'h44, 32'h000E_0000, 4'd7},   // R7 clear one bit
    '{1'b1, 8'h34, 32'h5, 4'd4},           // nonzero write keeps flag
    '{1'b0, 8'h34, 32'h1, 4'd4},           // R4
    '{1'b1, 8'h34, 32'h0, 4'd4},
    '{1'b0, 8'h34, 32'h0, 4'd4},           // R4 cleared
    '{1'b1, 8'h20, 32'h1, 4'd10},
    '{1'b0, 8'h60, 32'h2, 4'd10},          // R10 capture
    '{1'b1, 8'h08, 32'h0, 4'd10},          // non-trigger value ignored
    '{1'b1, 8'h58, 32'hFF, 4'd1},
    '{1'b0, 8'h58, 32'hF, 4'd1},           // R1 prescale field masked
    '{1'b0, 8'h7C, 32'h0, 4'd12}           // R12 unmapped read
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  initial begin : watchdog
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R11 irq after reset", {31'b0, irq}, 32'h0);

    for (int k = 0; k < NV; k++) begin
      if (TBL[k].wr) wr(TBL[k].addr, TBL[k].data);
      else begin
        rd(TBL[k].addr, v);
        check($sformatf("R%0d vector %0d", TBL[k].req, k), v, TBL[k].data);
      end
    end

    // R6 / R2: only channel 2 enabled, 8-bit wrap
    wr(8'h48, 32'h000F_0000);
    check("R7 clear all enables", {31'b0, irq}, 32'h0);
    wr(8'h44, 32'h0004_0000);
    wr(8'h0C, 32'h1);
    wr(8'h68, 32'hFF);
    for (int k = 0; k < 254; k++) wr(8'h08, 32'h1);
    check("R6 disabled events keep irq low", {31'b0, irq}, 32'h0);
    wr(8'h08, 32'h1);
    check("R6 enabled event raises irq", {31'b0, irq}, 32'h1);
    rd_chk("R4 event 2 at 255", 8'h38, 32'h1);
    wr(8'h08, 32'h1);
    wr(8'h2C, 32'h1);
    rd_chk("R2 8-bit wrap to zero", 8'h6C, 32'h0);
    wr(8'h38, 32'h0);
    check("R6 irq drops with event", {31'b0, irq}, 32'h0);

    // R5 clear shortcut on channel 1
    wr(8'h64, 32'h5);
    wr(8'h34, 32'h0);
    wr(8'h40, 32'h2);
    wr(8'h0C, 32'h1);
    for (int k = 0; k < 5; k++) wr(8'h08, 32'h1);
    wr(8'h20, 32'h1);
    rd_chk("R5 clear shortcut zeroes counter", 8'h60, 32'h0);
    rd_chk("R5 event still raised", 8'h34, 32'h1);
    wr(8'h08, 32'h1);
    wr(8'h20, 32'h1);
    rd_chk("R5 count resumes from zero", 8'h60, 32'h1);
    wr(8'h40, 32'h0);

    // R8 start ignored in counter mode
    wr(8'h0C, 32'h1);
    wr(8'h00, 32'h1);
    repeat (10) @(negedge clk);
    wr(8'h20, 32'h1);
    rd_chk("R8 start ignored in counter mode", 8'h60, 32'h0);

    // R1 / R8 timer mode, prescale 0: counts = repeats + 2
    wr(8'h50, 32'h0);
    wr(8'h54, 32'h3);
    wr(8'h58, 32'h0);
    wr(8'h0C, 32'h1);
    wr(8'h00, 32'h1);
    repeat (8) @(negedge clk);
    wr(8'h04, 32'h1);
    repeat (5) @(negedge clk);
    wr(8'h20, 32'h1);
    rd_chk("R1 prescale 0 advance count", 8'h60, 32'd10);

    // R1 prescale 2 with shutdown
    wr(8'h58, 32'h2);
    wr(8'h0C, 32'h1);
    wr(8'h00, 32'h1);
    repeat (38) @(negedge clk);
    wr(8'h10, 32'h1);
    repeat (5) @(negedge clk);
    wr(8'h20, 32'h1);
    rd_chk("R1 prescale 2 advance count", 8'h60, 32'd10);

    // R5 stop shortcut on channel 3
    wr(8'h58, 32'h0);
    wr(8'h0C, 32'h1);
    wr(8'h3C, 32'h0);
    wr(8'h6C, 32'h7);
    wr(8'h40, 32'h800);
    wr(8'h00, 32'h1);
    repeat (20) @(negedge clk);
    wr(8'h20, 32'h1);
    rd_chk("R5 stop shortcut halts at compare", 8'h60, 32'h7);
    rd_chk("R5 stop event set", 8'h3C, 32'h1);
    rd_chk("R5 shortcut readback", 8'h40, 32'h800);

    // R12 unmapped write
    wr(8'h7C, 32'hFFFF_FFFF);
    rd_chk("R12 unmapped write ignored", 8'h54, 32'h3);

    // R11 reset mid-run
    wr(8'h44, 32'h000F_0000);
    wr(8'h00, 32'h1);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R11 irq cleared", {31'b0, irq}, 32'h0);
    rd_chk("R11 enables cleared", 8'h44, 32'h0);
    rd_chk("R11 compare cleared", 8'h6C, 32'h0);
    rd_chk("R11 event cleared", 8'h3C, 32'h0);
    rd_chk("R11 prescale cleared", 8'h58, 32'h0);
    repeat (5) @(negedge clk);
    wr(8'h20, 32'h1);
    rd_chk("R11 counter zero and stopped", 8'h60, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule